// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a pulse-width modulator channel. A 16-bit counter steps on a time-base clock enable derived from the system clock by a two-stage prescaler. It counts up, counts down, counts up and down between zero and the period, or stays frozen. Downstream compare and waveform logic uses the counter value, the count direction and three equality flags: zero, period and compare-B.

The block is set up through one 16-bit control word and one period write port. A hardware sync pulse, or a one-shot software sync bit in the control word, can load the counter from a phase input. This keeps several channels aligned. The period takes effect either at once or through a shadow copy that is moved into the active period while the counter is zero. A sync output carries a selected event to the next channel. An emulation-halt input stops the counter right after its next step, stops it at the end of the current cycle, or is ignored.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction is up (`tb_up`=1), `ctl_rdata` reads 0x0083 and `prd_rdata` reads 0xFFFF. The count mode field (bits 1:0) resets to 3, which freezes the counter.
- R2: `tb_tick` pulses once every C×F system clocks. C is 1, 2, 4, 8, 16, 32, 64 or 128 for codes 0 to 7 of bits 12:10. F is 1 for code 0 and 2×code otherwise, taken from bits 9:7. A control write restarts the prescaler count, so the first tick comes C×F−1 cycles after the write edge. No tick occurs in a write cycle.
- R3: In mode 0 (up), the counter steps +1 per tick and wraps from the active period to 0. `tb_up` is 1.
- R4: In mode 1 (down), the counter steps −1 per tick and reloads the active period after 0. `tb_up` is 0.
- R5: In mode 2 (up-down), the counter reverses at the period (continuing down from period−1) and at 0 (continuing up to 1). `tb_up` shows the direction of the last step.
- R6: A mode change takes effect at the next tick and continues from the current counter value.
- R7: When bit 2 is set, the counter is loaded from `phase_val` at the clock edge of a `sync_in` pulse, or at the edge of a control write with bit 6 set. Loading takes priority over counting. When bit 2 is clear, sync events leave counting unchanged.
- R8: After a phase load in mode 2, the direction is up if bit 13 is 1 and down if it is 0. In modes 0 and 1, bit 13 is ignored and the direction follows the mode.
- R9: With bit 3 clear, period writes go to the shadow register. The shadow is read back on `prd_rdata` and copied to the active period on each clock where the counter is 0. With bit 3 set, writes and reads use the active period directly.
- R10: `sync_out` is selected by bits 5:4: 0 passes `sync_in` or a software sync write through, 1 gives counter==0, 2 gives counter==`cmpb_val`, and 3 holds it at 0.
- R11: While `emu_halt` is high, bits 15:14 choose the behaviour. Code 0 stops the counter after its next step. Code 1 stops it when it reaches the period going up or 0 going down. Codes 2 and 3 keep it running. Releasing `emu_halt` resumes counting at the next tick.
- R12: The software sync bit (bit 6) always reads back as 0. The other control bits read back as written.
- R13: `evt_zero`, `evt_prd` and `evt_cmpb` are high exactly when the counter equals 0, the active period and `cmpb_val`, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | CW | Period write data |
| phase_val | input | CW | Value loaded into the counter on sync |
| cmpb_val | input | CW | Compare-B value for the equality flag |
| sync_in | input | 1 | Hardware sync pulse |
| emu_halt | input | 1 | Debug halt request |
| ctl_rdata | output | 16 | Control word read-back |
| prd_rdata | output | CW | Period read-back (shadow or active) |
| tb_tick | output | 1 | Time-base clock enable |
| tb_cnt | output | CW | Counter value |
| tb_up | output | 1 | Direction, 1 = up |
| evt_zero | output | 1 | Counter equals zero |
| evt_prd | output | 1 | Counter equals active period |
| evt_cmpb | output | 1 | Counter equals compare-B |
| sync_out | output | 1 | Selected sync output |

## Verification
The hardest state to reach is a shadow period that differs from the active period while the counter is away from zero. The active period cannot be read while the shadow path is selected. The bench therefore writes a new shadow value mid-count and watches `evt_prd` rise at the old period value. It then sees the flag move to the new value only after a pass through zero. Halt-at-cycle-end needs the counter at a known phase, so each halt case begins with a software sync that loads phase 0.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDN   = 2'd2,
    MODE_FREEZE = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SYNC_PASS = 2'd0,
    SYNC_ZERO = 2'd1,
    SYNC_CMPB = 2'd2,
    SYNC_OFF  = 2'd3
  } sync_src_e;

  typedef enum logic [1:0] {
    EMU_STEP  = 2'd0,
    EMU_CYCLE = 2'd1,
    EMU_RUN2  = 2'd2,
    EMU_RUN3  = 2'd3
  } emu_e;

  // Control word; field positions are the software-visible layout.
  typedef struct packed {
    emu_e      emu_mode;      // 15:14
    logic      post_sync_up;  // 13
    logic [2:0] coarse_div;   // 12:10
    logic [2:0] fine_div;     // 9:7
    logic      force_sync;    // 6
    sync_src_e sync_src;      // 5:4
    logic      prd_direct;    // 3
    logic      phase_en;      // 2
    cnt_mode_e count_mode;    // 1:0
  } ctl_t;

  localparam int          PRE_W     = 11;
  localparam logic [15:0] CTL_RESET = 16'h0083;

  function automatic logic [7:0] coarse_factor(input logic [2:0] code);
    return 8'd1 << code;
  endfunction

  function automatic logic [3:0] fine_factor(input logic [2:0] code);
    return (code == 3'd0) ? 4'd1 : {code, 1'b0};
  endfunction

  function automatic logic [PRE_W-1:0] prescale_total(input logic [2:0] c,
                                                      input logic [2:0] f);
    return PRE_W'(coarse_factor(c)) * PRE_W'(fine_factor(f));
  endfunction

endpackage

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale
  import pwmtb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] coarse,
  input  logic [2:0] fine,
  output logic       tick
);
  logic [PRE_W-1:0] total;
  logic [PRE_W-1:0] pre_q;
  logic             at_end;

  assign total  = prescale_total(coarse, fine);
  assign at_end = (pre_q >= total - 1'b1);
  assign tick   = at_end && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_q <= '0;
    else if (clr || at_end) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && total != PRE_W'(1)) |=> !tick);

endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         direct,
  input  logic         at_zero,
  output logic [W-1:0] active,
  output logic [W-1:0] rdata
);
  logic [W-1:0] sh_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      act_q <= '1;
    end else begin
      if (we && !direct) sh_q <= wdata;
      if (we && direct)             act_q <= wdata;
      else if (!direct && at_zero)  act_q <= sh_q;
    end
  end

  assign active = act_q;
  assign rdata  = direct ? act_q : sh_q;

  // R9
  shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && at_zero) |=> act_q == $past(sh_q));
  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && !at_zero) |=> $stable(act_q));

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] prd,
  input  logic         load,
  input  logic [W-1:0] phase,
  input  logic         post_up,
  input  logic         emu_halt,
  input  emu_e         emu_mode,
  output logic [W-1:0] cnt,
  output logic         up
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         up_q, up_n;
  logic         stop_q;
  logic         step_en;
  logic         end_hit;

  assign step_en = tick && (mode != MODE_FREEZE) && !(stop_q && emu_halt);

  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    case (mode)
      MODE_UP: begin
        up_n  = 1'b1;
        cnt_n = (cnt_q == prd) ? '0 : cnt_q + 1'b1;
      end
      MODE_DOWN: begin
        up_n  = 1'b0;
        cnt_n = (cnt_q == '0) ? prd : cnt_q - 1'b1;
      end
      MODE_UPDN: begin
        if (up_q) begin
          if (cnt_q >= prd) begin
            up_n  = 1'b0;
            cnt_n = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            up_n  = 1'b1;
            cnt_n = (prd == '0) ? '0 : W'(1);
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign end_hit = (up_n && cnt_n == prd) || (!up_n && cnt_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (load) begin
      cnt_q <= phase;
      up_q  <= (mode == MODE_UPDN) ? post_up : (mode != MODE_DOWN);
    end else if (step_en) begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_q <= 1'b0;
    else if (!emu_halt) stop_q <= 1'b0;
    else if (step_en && !load &&
             (emu_mode == EMU_STEP || (emu_mode == EMU_CYCLE && end_hit)))
      stop_q <= 1'b1;
  end

  assign cnt = cnt_q;
  assign up  = up_q;

  // R1
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREEZE && !load) |=> $stable(cnt_q));
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && mode == MODE_UP && cnt_q != prd) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load && mode == MODE_DOWN && cnt_q == '0) |=> cnt_q == $past(prd));
  // R7
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(phase));
  // R8
  phase_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == MODE_UPDN) |=> up_q == $past(post_up));
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && emu_halt && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [15:0]   ctl_wdata,
  input  logic          prd_we,
  input  logic [CW-1:0] prd_wdata,
  input  logic [CW-1:0] phase_val,
  input  logic [CW-1:0] cmpb_val,
  input  logic          sync_in,
  input  logic          emu_halt,
  output logic [15:0]   ctl_rdata,
  output logic [CW-1:0] prd_rdata,
  output logic          tb_tick,
  output logic [CW-1:0] tb_cnt,
  output logic          tb_up,
  output logic          evt_zero,
  output logic          evt_prd,
  output logic          evt_cmpb,
  output logic          sync_out
);
  ctl_t          ctl_q, wr_ctl, wr_clean;
  cnt_mode_e     mode_eff;
  emu_e          emu_eff;
  logic          post_up_eff, phase_en_eff;
  logic          sw_sync, sync_evt, load;
  logic [CW-1:0] prd_act;

  always_comb begin
    wr_ctl              = ctl_t'(ctl_wdata);
    wr_clean            = wr_ctl;
    wr_clean.force_sync = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= ctl_t'(CTL_RESET);
    else if (ctl_we) ctl_q <= wr_clean;
  end

  assign mode_eff     = ctl_we ? wr_ctl.count_mode   : ctl_q.count_mode;
  assign emu_eff      = ctl_we ? wr_ctl.emu_mode     : ctl_q.emu_mode;
  assign post_up_eff  = ctl_we ? wr_ctl.post_sync_up : ctl_q.post_sync_up;
  assign phase_en_eff = ctl_we ? wr_ctl.phase_en     : ctl_q.phase_en;

  assign sw_sync  = ctl_we && wr_ctl.force_sync;
  assign sync_evt = sync_in || sw_sync;
  assign load     = sync_evt && phase_en_eff;

  pwmtb_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ctl_we),
    .coarse (ctl_q.coarse_div),
    .fine   (ctl_q.fine_div),
    .tick   (tb_tick)
  );

  pwmtb_period #(.W(CW)) u_prd (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (prd_we),
    .wdata   (prd_wdata),
    .direct  (ctl_q.prd_direct),
    .at_zero (evt_zero),
    .active  (prd_act),
    .rdata   (prd_rdata)
  );

  pwmtb_counter #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tb_tick),
    .mode     (mode_eff),
    .prd      (prd_act),
    .load     (load),
    .phase    (phase_val),
    .post_up  (post_up_eff),
    .emu_halt (emu_halt),
    .emu_mode (emu_eff),
    .cnt      (tb_cnt),
    .up       (tb_up)
  );

  assign evt_zero  = (tb_cnt == '0);
  assign evt_prd   = (tb_cnt == prd_act);
  assign evt_cmpb  = (tb_cnt == cmpb_val);
  assign ctl_rdata = ctl_q;

  always_comb begin
    case (ctl_q.sync_src)
      SYNC_PASS: sync_out = sync_evt;
      SYNC_ZERO: sync_out = evt_zero;
      SYNC_CMPB: sync_out = evt_cmpb;
      default:   sync_out = 1'b0;
    endcase
  end

  // R12
  force_sync_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] == 1'b0);
  // R10
  sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[5:4] == 2'd3) |-> !sync_out);

endmodule

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic          prd_we = 1'b0;
  logic [CW-1:0] prd_wdata = '0;
  logic [CW-1:0] phase_val = '0;
  logic [CW-1:0] cmpb_val = 16'd2;
  logic          sync_in = 1'b0;
  logic          emu_halt = 1'b0;
  logic [15:0]   ctl_rdata;
  logic [CW-1:0] prd_rdata;
  logic          tb_tick;
  logic [CW-1:0] tb_cnt;
  logic          tb_up;
  logic          evt_zero, evt_prd, evt_cmpb, sync_out;

  pwm_timebase #(.CW(CW)) i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prd_we(prd_we), .prd_wdata(prd_wdata), .phase_val(phase_val),
    .cmpb_val(cmpb_val), .sync_in(sync_in), .emu_halt(emu_halt),
    .ctl_rdata(ctl_rdata), .prd_rdata(prd_rdata), .tb_tick(tb_tick),
    .tb_cnt(tb_cnt), .tb_up(tb_up), .evt_zero(evt_zero), .evt_prd(evt_prd),
    .evt_cmpb(evt_cmpb), .sync_out(sync_out)
  );

  always #10 clk = ~clk;

  // Scoreboard item: which output to look at and its expected value.
  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  localparam int S_CNT = 0, S_UP = 1, S_CTL = 2, S_PRD = 3, S_SYNC = 4,
                 S_EVT = 5, S_GAP = 6, S_TICK = 7;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  int    since_tick = 0;
  int    last_gap = 0;
  bit    done = 1'b0;

  function automatic int pick(int sel);
    case (sel)
      S_CNT:  return int'(tb_cnt);
      S_UP:   return int'(tb_up);
      S_CTL:  return int'(ctl_rdata);
      S_PRD:  return int'(prd_rdata);
      S_SYNC: return int'(sync_out);
      S_EVT:  return int'({evt_zero, evt_prd, evt_cmpb});
      S_GAP:  return last_gap;
      default: return int'(tb_tick);
    endcase
  endfunction

  // Monitor: samples away from the edge and drains the expectation queue.
  always @(negedge clk) begin
    #2;
    if (tb_tick) begin
      last_gap   = since_tick;
      since_tick = 1;
    end else begin
      since_tick = since_tick + 1;
    end
    while (q.size() > 0) begin
      item_t it;
      int    act;
      it  = q.pop_front();
      act = pick(it.sel);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr_ctl(logic [15:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    cyc(1);
    ctl_we = 1'b0;
  endtask

  task automatic wr_prd(logic [15:0] v);
    prd_wdata = v; prd_we = 1'b1;
    cyc(1);
    prd_we = 1'b0;
  endtask

  task automatic sync_pulse();
    sync_in = 1'b1;
    cyc(1);
    sync_in = 1'b0;
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    // R1 reset state
    expect_val("R1", S_CNT, 0);
    expect_val("R1", S_UP, 1);
    expect_val("R1", S_CTL, 16'h0083);
    expect_val("R1", S_PRD, 16'hFFFF);
    expect_val("R13", S_EVT, 3'b100);
    cyc(10);
    expect_val("R1", S_CNT, 0);

    // R2 prescaler: /4 x /6 = 24
    wr_ctl(16'h0983);
    cyc(22); expect_val("R2", S_TICK, 0);
    cyc(1);  expect_val("R2", S_TICK, 1);
    cyc(60); expect_val("R2", S_GAP, 24);
    wr_ctl(16'h0383);
    cyc(40); expect_val("R2", S_GAP, 14);
    wr_ctl(16'h1C03);
    cyc(300); expect_val("R2", S_GAP, 128);
    expect_val("R12", S_CTL, 16'h1C03);

    // R3 up count, direct period 4
    wr_ctl(16'h000B);
    wr_prd(16'd4);
    expect_val("R9", S_PRD, 4);
    wr_ctl(16'h0008);
    expect_val("R3", S_CNT, 0);
    cyc(4); expect_val("R3", S_CNT, 4); expect_val("R13", S_EVT, 3'b010);
    expect_val("R3", S_UP, 1);
    cyc(1); expect_val("R3", S_CNT, 0);
    cyc(2); expect_val("R13", S_EVT, 3'b001);

    // R6 mode change keeps value; R4 down count
    wr_ctl(16'h0009);
    expect_val("R6", S_CNT, 2);
    cyc(1); expect_val("R4", S_CNT, 1); expect_val("R4", S_UP, 0);
    cyc(1); expect_val("R4", S_CNT, 0);
    cyc(1); expect_val("R4", S_CNT, 4);
    cyc(1); expect_val("R4", S_CNT, 3);

    // R5 up-down
    wr_ctl(16'h000A);
    expect_val("R6", S_CNT, 3);
    cyc(3); expect_val("R5", S_CNT, 0); expect_val("R5", S_UP, 0);
    cyc(1); expect_val("R5", S_CNT, 1); expect_val("R5", S_UP, 1);
    cyc(3); expect_val("R5", S_CNT, 4); expect_val("R5", S_UP, 1);
    cyc(1); expect_val("R5", S_CNT, 3); expect_val("R5", S_UP, 0);

    // R7/R8 phase load by sync_in, post-sync direction up
    phase_val = 16'd2;
    wr_ctl(16'h200E);
    sync_in = 1'b1;
    expect_val("R10", S_SYNC, 1);
    cyc(1);
    sync_in = 1'b0;
    expect_val("R7", S_CNT, 2); expect_val("R8", S_UP, 1);
    cyc(1); expect_val("R8", S_CNT, 3);

    // software sync, post-sync direction down
    wr_ctl(16'h004E);
    expect_val("R7", S_CNT, 2); expect_val("R8", S_UP, 0);
    expect_val("R12", S_CTL, 16'h000E);
    cyc(1); expect_val("R8", S_CNT, 1);

    // phase load disabled: sync has no effect
    wr_ctl(16'h000A);
    sync_pulse();
    expect_val("R7", S_CNT, 0);

    // direction bit ignored in down mode
    wr_ctl(16'h200D);
    sync_pulse();
    expect_val("R8", S_CNT, 2); expect_val("R8", S_UP, 0);
    cyc(1); expect_val("R8", S_CNT, 1);

    // R9 shadowed period
    phase_val = 16'd0;
    wr_ctl(16'h0047);
    expect_val("R7", S_CNT, 0);
    expect_val("R12", S_CTL, 16'h0007);
    wr_prd(16'd6);
    expect_val("R9", S_PRD, 6);
    wr_ctl(16'h0000);
    cyc(6); expect_val("R9", S_CNT, 6); expect_val("R9", S_EVT, 3'b010);
    cyc(1); expect_val("R9", S_CNT, 0);
    cyc(3);
    wr_prd(16'd2);
    expect_val("R9", S_PRD, 2); expect_val("R9", S_CNT, 4);
    cyc(2); expect_val("R9", S_CNT, 6); expect_val("R9", S_EVT, 3'b010);
    cyc(1); expect_val("R9", S_CNT, 0);
    cyc(1); expect_val("R9", S_CNT, 1);
    cyc(1); expect_val("R9", S_CNT, 2); expect_val("R9", S_EVT, 3'b011);
    cyc(1); expect_val("R9", S_CNT, 0);

    // R10 sync output sources
    wr_ctl(16'h0010);
    expect_val("R10", S_SYNC, 1);
    cyc(1); expect_val("R10", S_SYNC, 0);
    wr_ctl(16'h0020);
    expect_val("R10", S_SYNC, 0);
    cyc(1); expect_val("R10", S_SYNC, 1);
    wr_ctl(16'h0030);
    sync_in = 1'b1;
    expect_val("R10", S_SYNC, 0);
    cyc(1);
    sync_in = 1'b0;

    // R11 halt code 0: stop after next step
    wr_ctl(16'h0044);
    emu_halt = 1'b1;
    cyc(1); expect_val("R11", S_CNT, 1);
    cyc(3); expect_val("R11", S_CNT, 1);
    emu_halt = 1'b0;
    cyc(1); expect_val("R11", S_CNT, 2);

    // code 1 up: stop at period
    wr_ctl(16'h4044);
    emu_halt = 1'b1;
    cyc(2); expect_val("R11", S_CNT, 2);
    cyc(4); expect_val("R11", S_CNT, 2);
    emu_halt = 1'b0;
    cyc(1); expect_val("R11", S_CNT, 0);

    // code 1 down: stop at zero
    wr_ctl(16'h4045);
    emu_halt = 1'b1;
    cyc(2); expect_val("R11", S_CNT, 1);
    cyc(4); expect_val("R11", S_CNT, 0);
    emu_halt = 1'b0;
    cyc(1); expect_val("R11", S_CNT, 2);

    // code 2: free run
    wr_ctl(16'h8044);
    emu_halt = 1'b1;
    cyc(4); expect_val("R11", S_CNT, 1);
    emu_halt = 1'b0;

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule